// File: doc/BRIEF.md
# Stacked Register Frame Mapper

This block turns a logical integer register index into a physical index for a 128-entry register file. The lowest 32 indices are global and pass through unchanged. The upper 96 physical registers form a circular pool of procedure frames. The running procedure sees its stacked registers through a moving base. A call allocates a fresh frame directly above the caller's frame, and a return brings the caller's frame back. Registers are renamed by changing the base, so no data is copied.

The current frame (base and size) is held in a register. Up to eight earlier frames are kept in an on-chip last-in/first-out save stack. The mapper also tracks the number of live stacked registers so it can refuse a call that would exceed the pool. A refused call, or a lookup of a stacked index outside the current frame, raises the overflow flag.

The lookup path is purely combinational. The call and return controls are plain single-cycle pulses with no handshake. A refused call is dropped, and the caller is expected to act on the overflow flag in that same cycle.

Top module: `regframe_mapper`

## Requirements
- R1: A logical index below 32 maps to the same physical index, whatever the frame state is.
- R2: A logical index L of 32 or more maps to physical 32 + ((base + L − 32) mod 96). The result is produced combinationally in the same cycle.
- R3: After reset the frame base is 0, the frame size is 0, the live count is 0 and the save stack is empty.
- R4: An accepted call sets the new base to (old base + old size) mod 96 and the new size to the requested size. It also pushes the old frame onto the save stack. The new values appear on the outputs after the next rising clock edge.
- R5: A return with a non-empty save stack restores the most recently saved base and size after the next rising clock edge, and frees the returning frame's registers from the live count.
- R6: A lookup of a stacked index whose offset (L − 32) is at or beyond the current frame size raises overflow in the same cycle.
- R7: A return while the save stack is empty is ignored, and base and size keep their values.
- R8: A call is refused when the live count plus the requested size would exceed 96, or when all 8 save slots are full. A refused call raises overflow in the same cycle and leaves base, size and the save stack unchanged.
- R9: When a call and a return are requested in the same cycle, the call is handled and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_idx | input | 7 | Logical register index to translate |
| call_req | input | 1 | Allocate a new frame on the next edge |
| call_size | input | 7 | Number of stacked registers requested by the call |
| ret_req | input | 1 | Restore the previous frame on the next edge |
| phys_idx | output | 7 | Physical register index for log_idx |
| frame_base | output | 7 | Current frame base within the stacked pool (0 to 95) |
| frame_size | output | 7 | Current frame size (0 to 96) |
| overflow | output | 1 | Out-of-frame lookup or refused call, this cycle |

## Verification
Translation and overflow are combinational. The bench drives log_idx and the call inputs just after a falling edge and reads phys_idx and overflow 1 ns later, inside the same cycle. Frame changes from a call or a return pass through one register stage. The bench holds the request across exactly one rising edge and reads frame_base and frame_size after the following falling edge. For refused and ignored requests it reads the unchanged frame state at that same point, then runs a return or a further lookup to show that the save stack was not touched.

// File: rtl/regframe_pkg.sv
package regframe_pkg;
  localparam int RIDX_W = 7;

  typedef struct packed {
    logic [RIDX_W-1:0] base;
    logic [RIDX_W-1:0] size;
  } frame_t;
endpackage

// File: rtl/frame_index_xlate.sv
module frame_index_xlate
  import regframe_pkg::*;
#(
  parameter int NUM_GLOBAL  = 32,
  parameter int NUM_STACKED = 96
) (
  input  logic [RIDX_W-1:0] log_idx,
  input  logic [RIDX_W-1:0] base,
  input  logic [RIDX_W-1:0] size,
  output logic [RIDX_W-1:0] phys_idx,
  output logic              out_of_frame
);
  localparam logic [RIDX_W-1:0] GLB = RIDX_W'(NUM_GLOBAL);
  localparam logic [RIDX_W:0]   STK = (RIDX_W+1)'(NUM_STACKED);

  logic              is_stacked;
  logic [RIDX_W-1:0] offset;
  logic [RIDX_W:0]   raw_sum;
  logic [RIDX_W:0]   rel;

  always_comb begin
    is_stacked = (log_idx >= GLB);
    offset     = log_idx - GLB;
    raw_sum    = {1'b0, base} + {1'b0, offset};
    rel        = (raw_sum >= STK) ? (raw_sum - STK) : raw_sum;
    phys_idx   = is_stacked ? (GLB + rel[RIDX_W-1:0]) : log_idx;
    out_of_frame = is_stacked && (offset >= size);
  end
endmodule

// File: rtl/frame_save_stack.sv
module frame_save_stack
  import regframe_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  frame_t        push_frame,
  output frame_t        top_frame,
  output logic [DW-1:0] level
);
  frame_t          slot [DEPTH];
  logic [DW-1:0]   level_q;
  logic [DW-1:0]   top_ptr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (push && (level_q == DW'(i)))
        slot[i] <= push_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      level_q <= '0;
    else if (push)
      level_q <= level_q + 1'b1;
    else if (pop)
      level_q <= level_q - 1'b1;
  end

  always_comb begin
    top_ptr   = level_q - 1'b1;
    top_frame = (level_q != '0) ? slot[top_ptr[AW-1:0]] : '0;
  end

  assign level = level_q;
endmodule

// File: rtl/regframe_mapper.sv
module regframe_mapper
  import regframe_pkg::*;
#(
  parameter int NUM_GLOBAL  = 32,
  parameter int NUM_STACKED = 96,
  parameter int SAVE_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] log_idx,
  input  logic              call_req,
  input  logic [RIDX_W-1:0] call_size,
  input  logic              ret_req,
  output logic [RIDX_W-1:0] phys_idx,
  output logic [RIDX_W-1:0] frame_base,
  output logic [RIDX_W-1:0] frame_size,
  output logic              overflow
);
  localparam int DW = $clog2(SAVE_DEPTH + 1);
  localparam logic [RIDX_W:0] STK = (RIDX_W+1)'(NUM_STACKED);

  logic [RIDX_W-1:0] base_q, size_q, live_q;
  logic [DW-1:0]     depth_q;
  frame_t            saved_top;
  frame_t            cur_frame;
  logic              idx_fault;
  logic [RIDX_W:0]   need_live;
  logic [RIDX_W:0]   next_sum;
  logic [RIDX_W:0]   next_base;
  logic              call_ok, call_bad, ret_ok;

  frame_index_xlate #(
    .NUM_GLOBAL (NUM_GLOBAL),
    .NUM_STACKED(NUM_STACKED)
  ) u_xlate (
    .log_idx     (log_idx),
    .base        (base_q),
    .size        (size_q),
    .phys_idx    (phys_idx),
    .out_of_frame(idx_fault)
  );

  always_comb begin
    need_live = {1'b0, live_q} + {1'b0, call_size};
    call_ok   = call_req && (need_live <= STK) && (depth_q != DW'(SAVE_DEPTH));
    call_bad  = call_req && !call_ok;
    ret_ok    = ret_req && !call_req && (depth_q != '0);
    next_sum  = {1'b0, base_q} + {1'b0, size_q};
    next_base = (next_sum >= STK) ? (next_sum - STK) : next_sum;
    cur_frame.base = base_q;
    cur_frame.size = size_q;
  end

  frame_save_stack #(
    .DEPTH(SAVE_DEPTH)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (call_ok),
    .pop       (ret_ok),
    .push_frame(cur_frame),
    .top_frame (saved_top),
    .level     (depth_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      live_q <= '0;
    end else if (call_ok) begin
      base_q <= next_base[RIDX_W-1:0];
      size_q <= call_size;
      live_q <= need_live[RIDX_W-1:0];
    end else if (ret_ok) begin
      base_q <= saved_top.base;
      size_q <= saved_top.size;
      live_q <= live_q - size_q;
    end
  end

  assign frame_base = base_q;
  assign frame_size = size_q;
  assign overflow   = idx_fault || call_bad;
endmodule

// File: rtl/regframe_mapper_chk.sv
module regframe_mapper_chk #(
  parameter int NUM_GLOBAL  = 32,
  parameter int NUM_STACKED = 96,
  parameter int SAVE_DEPTH  = 8,
  localparam int DW = $clog2(SAVE_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    log_idx,
  input logic          call_req,
  input logic [6:0]    call_size,
  input logic          ret_req,
  input logic [6:0]    phys_idx,
  input logic [6:0]    frame_base,
  input logic [6:0]    frame_size,
  input logic          overflow,
  input logic [6:0]    live,
  input logic [DW-1:0] depth
);
  AST_GLOBAL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(log_idx) < NUM_GLOBAL) |-> (phys_idx == log_idx)); // R1

  AST_STACK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(log_idx) >= NUM_GLOBAL) |-> (int'(phys_idx) >= NUM_GLOBAL)); // R2

  AST_CALL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !overflow && int'(log_idx) < NUM_GLOBAL) |=>
      (frame_size == $past(call_size)) &&
      (int'(frame_base) == (int'($past(frame_base)) + int'($past(frame_size))) % NUM_STACKED)); // R4

  AST_OUT_OF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(log_idx) >= NUM_GLOBAL && int'(log_idx) - NUM_GLOBAL >= int'(frame_size)) |-> overflow); // R6

  AST_EMPTY_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req && depth == '0) |=> ($stable(frame_base) && $stable(frame_size))); // R7

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && (int'(live) + int'(call_size) > NUM_STACKED || int'(depth) == SAVE_DEPTH)) |-> overflow); // R8

  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && (int'(live) + int'(call_size) > NUM_STACKED || int'(depth) == SAVE_DEPTH)) |=>
      ($stable(frame_base) && $stable(frame_size) && $stable(depth))); // R8

  AST_LIVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(live) <= NUM_STACKED); // R8
endmodule

bind regframe_mapper regframe_mapper_chk #(
  .NUM_GLOBAL (NUM_GLOBAL),
  .NUM_STACKED(NUM_STACKED),
  .SAVE_DEPTH (SAVE_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .log_idx   (log_idx),
  .call_req  (call_req),
  .call_size (call_size),
  .ret_req   (ret_req),
  .phys_idx  (phys_idx),
  .frame_base(frame_base),
  .frame_size(frame_size),
  .overflow  (overflow),
  .live      (live_q),
  .depth     (depth_q)
);

// File: tb/regframe_mapper_test.sv
`timescale 1ns/1ps
module regframe_mapper_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] log_idx = '0;
  logic       call_req = 1'b0;
  logic [6:0] call_size = '0;
  logic       ret_req = 1'b0;
  logic [6:0] phys_idx, frame_base, frame_size;
  logic       overflow;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  regframe_mapper uut (
    .clk(clk), .rst_n(rst_n), .log_idx(log_idx), .call_req(call_req),
    .call_size(call_size), .ret_req(ret_req), .phys_idx(phys_idx),
    .frame_base(frame_base), .frame_size(frame_size), .overflow(overflow)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    call_req = 0; ret_req = 0; log_idx = 0; call_size = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
  endtask

  task automatic frame_is(string req, int b, int s);
    chk(req, "frame_base", int'(frame_base), b);
    chk(req, "frame_size", int'(frame_size), s);
  endtask

  task automatic look(string req, int l, int p, int ov);
    log_idx = 7'(l);
    #1;
    chk(req, "phys_idx", int'(phys_idx), p);
    chk(req, "overflow", int'(overflow), ov);
  endtask

  // call issued with a global lookup index so overflow reflects only the call
  task automatic do_call(string req, int sz, int exp_ov);
    log_idx = 0; call_size = 7'(sz); call_req = 1;
    #1;
    chk(req, "call overflow", int'(overflow), exp_ov);
    @(negedge clk);
    call_req = 0;
    #1;
  endtask

  task automatic do_ret();
    ret_req = 1;
    @(negedge clk);
    ret_req = 0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    frame_is("R3", 0, 0);
    look("R3", 32, 32, 1);
  endtask

  task automatic t_globals();
    do_reset();
    do_call("R4", 20, 0);
    look("R1", 0, 0, 0);
    look("R1", 31, 31, 0);
  endtask

  task automatic t_call_return();
    do_reset();
    do_call("R4", 10, 0);
    frame_is("R4", 0, 10);
    look("R2", 41, 41, 0);
    look("R6", 42, 42, 1);
    do_call("R4", 20, 0);
    frame_is("R4", 10, 20);
    look("R2", 32, 42, 0);
    look("R2", 51, 61, 0);
    do_ret();
    frame_is("R5", 0, 10);
    do_ret();
    frame_is("R5", 0, 0);
  endtask

  task automatic t_reject_live();
    do_reset();
    do_call("R4", 50, 0);
    do_call("R8", 50, 1);
    frame_is("R8", 0, 50);
    do_call("R8", 46, 0);
    frame_is("R4", 50, 46);
    look("R2", 77, 127, 0);
    look("R6", 78, 32, 1);
    do_ret();
    frame_is("R5", 0, 50);
    do_call("R5", 46, 0);
    frame_is("R5", 50, 46);
  endtask

  task automatic t_stack_full();
    do_reset();
    for (int k = 0; k < 8; k++) do_call("R4", 2, 0);
    frame_is("R4", 14, 2);
    do_call("R8", 2, 1);
    frame_is("R8", 14, 2);
    do_ret();
    frame_is("R8", 12, 2);
  endtask

  task automatic t_empty_ret();
    do_reset();
    do_ret();
    frame_is("R7", 0, 0);
    do_call("R7", 5, 0);
    do_ret();
    frame_is("R7", 0, 0);
    do_ret();
    frame_is("R7", 0, 0);
  endtask

  task automatic t_call_and_ret();
    do_reset();
    do_call("R9", 10, 0);
    log_idx = 0; call_size = 5; call_req = 1; ret_req = 1;
    @(negedge clk);
    call_req = 0; ret_req = 0;
    #1;
    frame_is("R9", 10, 5);
    do_ret();
    frame_is("R9", 0, 10);
  endtask

  task automatic t_full_pool_wrap();
    do_reset();
    do_call("R4", 96, 0);
    look("R2", 127, 127, 0);
    do_call("R4", 0, 0);
    frame_is("R4", 0, 0);
    look("R6", 32, 32, 1);
    do_call("R8", 1, 1);
    do_ret();
    frame_is("R5", 0, 96);
  endtask

  initial begin
    t_reset();
    t_globals();
    t_call_return();
    t_reject_live();
    t_stack_full();
    t_empty_ret();
    t_call_and_ret();
    t_full_pool_wrap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule